// File: doc/BRIEF.md
# Conversion Result Bank with Prioritised Interrupt

This block holds the results of an analog-to-digital converter. It has sixteen entries, and each stores a 12-bit value. The conversion sequencer writes a result into an entry through a write strobe with an address. Software reads entries back over a simple synchronous read port, and each read returns a 16-bit word whose upper four bits are zero. Each entry has a pending flag. A result write sets the flag, and a bus read of that entry clears it.

Two error conditions are tracked beside the result flags. The first is an overwrite: a new result lands in an entry whose flag is still set. The second is a timing overlap: the sequencer reports that a new sample request arrived before the current conversion finished. Each of the eighteen sources has its own enable bit. All eighteen fold into one interrupt request line and one vector value, and the vector names the highest-priority pending source that is enabled. Strobing the vector-read input acknowledges an error source that the vector is currently reporting.

Top module: `result_bank_irq`

## Requirements
- R1: After reset, every entry holds 0, all flags and enables are clear, rd_data is 0, irq is 0 and irq_vec is 0.
- R2: One cycle after a cycle with rd_en high, rd_data shows the entry at rd_addr as it was before that edge, in bits 11:0, with bits 15:12 equal to 0. rd_data holds its value while rd_en is low.
- R3: A write with wr_en stores wr_data in entry wr_addr and sets flag wr_addr. A read of entry x clears flag x.
- R4: If a read and a write address the same entry in the same cycle, the write wins. The read returns the old value and the flag stays set.
- R5: An enable bit that is 0 keeps its source off irq and irq_vec, but the flag stays stored. Setting the enable bit later raises the request.
- R6: A write into an entry whose flag is already set raises the overflow flag. The overflow flag is enabled by ie_wdata bit 16.
- R7: A tov_evt pulse raises the time-overflow flag. The time-overflow flag is enabled by ie_wdata bit 17.
- R8: Among enabled pending sources, priority runs overflow first, then time-overflow, then result flag 0 up to result flag 15. irq_vec is 0 when no source is pending, 2 for overflow, 4 for time-overflow and 6+2x for result flag x. irq is 1 exactly when irq_vec is nonzero.
- R9: vec_rd clears the overflow flag when irq_vec reads 2, and clears the time-overflow flag when irq_vec reads 4. It leaves result flags unchanged. A set event in the same cycle wins over the clear.
- R10: ie_wr loads all eighteen enable bits at once from ie_wdata: bits 15:0 enable the result flags, bit 16 enables overflow and bit 17 enables time-overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Result write strobe from the sequencer |
| wr_addr | input | 4 | Entry written |
| wr_data | input | 12 | Conversion value |
| tov_evt | input | 1 | Sample request arrived while a conversion was still running |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | 4 | Entry read |
| rd_data | output | 16 | Read result, registered |
| ie_wr | input | 1 | Enable register write strobe |
| ie_wdata | input | 18 | New enable bits |
| vec_rd | input | 1 | Vector acknowledge strobe |
| irq | output | 1 | Combined interrupt request |
| irq_vec | output | 6 | Code of the highest-priority enabled pending source |

## Verification
The bench targets several corner cases:
- A read and a write to the same entry in the same cycle. A design that lets the read win drops a pending result, and irq_vec then skips that entry.
- A pending result with its enable bit clear. Such a flag must stay stored, so a design that discards it never raises irq once the enable is set.
- Both error flags pending at once. Acknowledging them must clear them one at a time, in priority order.
- A vector acknowledge issued while a result flag is reported. A design that clears the result flag here loses the interrupt.
- A masked overflow. A design that ignores bit 16 reports vector 2 while the source is masked.

// File: rtl/rib_pkg.sv
package rib_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_OV   = 2'd1,
        SRC_TOV  = 2'd2,
        SRC_RES  = 2'd3
    } src_kind_e;

    localparam int VEC_OV   = 2;
    localparam int VEC_TOV  = 4;
    localparam int VEC_BASE = 6;
endpackage

// File: rtl/rib_result_regs.sv
module rib_result_regs #(
    parameter int NUM_ENTRIES = 16,
    parameter int DATA_W      = 12,
    parameter int ADDR_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [DATA_W-1:0]      rd_val,
    output logic [NUM_ENTRIES-1:0] flags,
    output logic                   overwrite
);
    logic [DATA_W-1:0] mem_q [NUM_ENTRIES];

    // A write hitting a still-pending entry
    assign overwrite = wr_en && flags[wr_addr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                mem_q[i] <= '0;
                flags[i] <= 1'b0;
            end
            rd_val <= '0;
        end else begin
            if (rd_en) rd_val <= mem_q[rd_addr];
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                if (wr_en && wr_addr == ADDR_W'(i)) begin
                    mem_q[i] <= wr_data;
                    flags[i] <= 1'b1;          // write wins over read
                end else if (rd_en && rd_addr == ADDR_W'(i)) begin
                    flags[i] <= 1'b0;
                end
            end
        end
    end

    AST_FLAG_SET_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> flags[$past(wr_addr)]);                                     // R3
    AST_FLAG_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !(wr_en && wr_addr == rd_addr)) |=> !flags[$past(rd_addr)]); // R3
    AST_COLLIDE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en && wr_addr == rd_addr) |=> flags[$past(rd_addr)]);     // R4
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_val));                                          // R2
endmodule

// File: rtl/rib_err_flags.sv
module rib_err_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic ov_set,
    input  logic ov_clr,
    input  logic tov_set,
    input  logic tov_clr,
    output logic ov_q,
    output logic tov_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_q  <= 1'b0;
            tov_q <= 1'b0;
        end else begin
            if (ov_set)       ov_q <= 1'b1;
            else if (ov_clr)  ov_q <= 1'b0;
            if (tov_set)      tov_q <= 1'b1;
            else if (tov_clr) tov_q <= 1'b0;
        end
    end

    AST_OV_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        ov_set |=> ov_q);                                   // R6
    AST_TOV_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        tov_set |=> tov_q);                                 // R7
    AST_OV_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_clr && !ov_set) |=> !ov_q);                     // R9
endmodule

// File: rtl/rib_prio_enc.sv
module rib_prio_enc
    import rib_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int VEC_W       = $clog2(2*NUM_ENTRIES+6)
) (
    input  logic                   req_ov,
    input  logic                   req_tov,
    input  logic [NUM_ENTRIES-1:0] req_res,
    output logic [VEC_W-1:0]       vec,
    output src_kind_e              kind
);
    logic [NUM_ENTRIES:0]   seen;
    logic [NUM_ENTRIES-1:0] grant;

    assign seen[0] = req_ov | req_tov;

    // Ripple chain: lower index outranks higher
    for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_chain
        assign grant[gi]    = req_res[gi] & ~seen[gi];
        assign seen[gi + 1] = seen[gi] | req_res[gi];
    end

    always_comb begin
        vec  = '0;
        kind = SRC_NONE;
        if (req_ov) begin
            vec  = VEC_W'(VEC_OV);
            kind = SRC_OV;
        end else if (req_tov) begin
            vec  = VEC_W'(VEC_TOV);
            kind = SRC_TOV;
        end else begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                if (grant[i]) begin
                    vec  = VEC_W'(VEC_BASE + 2*i);
                    kind = SRC_RES;
                end
            end
        end
    end

    always_comb begin
        AST_ONE_GRANT: assert ($onehot0(grant)); // R8
    end
endmodule

// File: rtl/result_bank_irq.sv
module result_bank_irq
    import rib_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int DATA_W      = 12,
    parameter int REG_W       = 16,
    parameter int ADDR_W      = $clog2(NUM_ENTRIES),
    parameter int VEC_W       = $clog2(2*NUM_ENTRIES+6)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   tov_evt,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [REG_W-1:0]       rd_data,
    input  logic                   ie_wr,
    input  logic [NUM_ENTRIES+1:0] ie_wdata,
    input  logic                   vec_rd,
    output logic                   irq,
    output logic [VEC_W-1:0]       irq_vec
);
    localparam int PAD_W  = REG_W - DATA_W;
    localparam int IE_W   = NUM_ENTRIES + 2;
    localparam int IE_OV  = NUM_ENTRIES;
    localparam int IE_TOV = NUM_ENTRIES + 1;

    logic [DATA_W-1:0]      rd_val;
    logic [NUM_ENTRIES-1:0] flags;
    logic                   overwrite;
    logic                   ov_q, tov_q;
    logic [IE_W-1:0]        ie_q;
    src_kind_e              kind;

    always_ff @(posedge clk) begin
        if (!rst_n)     ie_q <= '0;
        else if (ie_wr) ie_q <= ie_wdata;
    end

    rib_result_regs #(
        .NUM_ENTRIES(NUM_ENTRIES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_val(rd_val),
        .flags(flags), .overwrite(overwrite)
    );

    rib_err_flags u_err (
        .clk(clk), .rst_n(rst_n),
        .ov_set(overwrite), .ov_clr(vec_rd && kind == SRC_OV),
        .tov_set(tov_evt),  .tov_clr(vec_rd && kind == SRC_TOV),
        .ov_q(ov_q), .tov_q(tov_q)
    );

    rib_prio_enc #(
        .NUM_ENTRIES(NUM_ENTRIES), .VEC_W(VEC_W)
    ) u_prio (
        .req_ov(ov_q & ie_q[IE_OV]),
        .req_tov(tov_q & ie_q[IE_TOV]),
        .req_res(flags & ie_q[NUM_ENTRIES-1:0]),
        .vec(irq_vec),
        .kind(kind)
    );

    assign irq     = (ov_q & ie_q[IE_OV]) | (tov_q & ie_q[IE_TOV])
                   | (|(flags & ie_q[NUM_ENTRIES-1:0]));
    assign rd_data = {{PAD_W{1'b0}}, rd_val};

    AST_IRQ_MATCHES_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (irq_vec != '0));                                       // R8
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_q == '0) |-> !irq);                                        // R5
    AST_NO_OVERFLOW_ON_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (!ov_q && !overwrite) |=> !ov_q);                              // R6
    AST_VEC_ACK_KEEPS_RES: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && !rd_en) |=> (flags & $past(flags)) == $past(flags)); // R9
endmodule

// File: tb/tb_result_bank_irq.sv
module tb_result_bank_irq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, tov_evt = 1'b0, rd_en = 1'b0, ie_wr = 1'b0, vec_rd = 1'b0;
    logic [3:0]  wr_addr = '0, rd_addr = '0;
    logic [11:0] wr_data = '0;
    logic [17:0] ie_wdata = '0;
    logic [15:0] rd_data;
    logic        irq;
    logic [5:0]  irq_vec;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;
    logic [11:0] mdl [16];
    logic [15:0] exp_q [$];
    string       tag_q [$];
    logic        mon_arm = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    result_bank_irq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tov_evt(tov_evt), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .ie_wr(ie_wr), .ie_wdata(ie_wdata), .vec_rd(vec_rd), .irq(irq), .irq_vec(irq_vec)
    );

    // Monitor: pops the expected read word in the cycle after each read strobe
    always @(posedge clk) mon_arm <= rd_en;
    always @(negedge clk) begin
        if (mon_arm) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rd_data !== e) begin
                errors++;
                $display("FAIL %s: rd_data=%h expected %h", t, rd_data, e);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 50000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog: cycles=%0d expected completion", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wr(input int a, input logic [11:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = 4'(a); wr_data = d; mdl[a] = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input int a, input string t);
        @(negedge clk);
        rd_en = 1; rd_addr = 4'(a);
        exp_q.push_back({4'h0, mdl[a]}); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic set_ie(input logic [17:0] v);
        @(negedge clk); ie_wr = 1; ie_wdata = v;
        @(negedge clk); ie_wr = 0;
    endtask

    task automatic pulse_tov();
        @(negedge clk); tov_evt = 1;
        @(negedge clk); tov_evt = 0;
    endtask

    task automatic ack_vec();
        @(negedge clk); vec_rd = 1;
        @(negedge clk); vec_rd = 0;
    endtask

    task automatic chk(input int ev, input string t);
        @(negedge clk);
        checks++;
        if (irq_vec !== 6'(ev) || irq !== (ev != 0)) begin
            errors++;
            $display("FAIL %s: vec=%0d irq=%b expected vec=%0d irq=%b", t, irq_vec, irq, ev, ev != 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk(0, "R1 reset vector");
        rd(5, "R1 reset entry");

        set_ie(18'h3FFFF);                     // R10 all enables
        wr(3, 12'hABC);
        chk(12, "R3 flag3 vector");
        rd(3, "R2 read entry3");
        chk(0, "R3 flag3 cleared by read");

        wr(7, 12'hFFF); wr(2, 12'h123);
        chk(10, "R8 flag2 over flag7");
        rd(2, "R2 read entry2");
        chk(20, "R8 flag7 next");
        rd(7, "R2 read entry7 full scale");
        chk(0, "R3 all read");

        set_ie(18'h0);
        wr(0, 12'h055);
        chk(0, "R5 masked flag quiet");
        set_ie(18'h00001);
        chk(6, "R5 stored flag raises after enable");
        rd(0, "R2 read entry0");

        set_ie(18'h3FFFF);
        wr(4, 12'h001); wr(4, 12'h002);
        chk(2, "R6 overwrite raises overflow");
        ack_vec();
        chk(14, "R9 overflow acked, flag4 remains");
        rd(4, "R6 overwritten value");

        pulse_tov(); wr(1, 12'h321);
        chk(4, "R7 time overflow vector");
        ack_vec();
        chk(8, "R9 time overflow acked");
        ack_vec();
        chk(8, "R9 ack leaves result flag");
        rd(1, "R2 read entry1");

        pulse_tov(); wr(9, 12'h0AA); wr(9, 12'h0BB);
        chk(2, "R8 overflow beats time overflow");
        ack_vec();
        chk(4, "R8 time overflow after overflow ack");
        ack_vec();
        chk(24, "R8 flag9 last");
        rd(9, "R2 read entry9");
        chk(0, "R3 nothing pending");

        wr(6, 12'h111);
        @(negedge clk);                         // R4 same-cycle read and write
        rd_en = 1; rd_addr = 4'd6; wr_en = 1; wr_addr = 4'd6; wr_data = 12'h222;
        exp_q.push_back({4'h0, mdl[6]}); tag_q.push_back("R4 collision returns old value");
        mdl[6] = 12'h222;
        @(negedge clk);
        rd_en = 0; wr_en = 0;
        chk(2, "R6 collision write onto pending flag");
        ack_vec();
        chk(18, "R4 flag6 survives collision");
        rd(6, "R4 new value stored");
        chk(0, "R4 flag6 cleared");

        set_ie(18'h0FFFF);
        wr(10, 12'h010); wr(10, 12'h020);
        chk(26, "R6 overflow masked by bit16");
        set_ie(18'h1FFFF);
        chk(2, "R10 bit16 enables overflow");
        ack_vec();
        chk(26, "R9 overflow cleared");
        set_ie(18'h0);
        chk(0, "R10 enables cleared");
        rd(10, "R2 read entry10");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2: pending reads=%0d expected 0", exp_q.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule